// File: doc/BRIEF.md
# Keyed Configuration Item Port

This block is a configuration store that a host reaches through two ports. A control-port write of a 16-bit key chooses one item, and the data port then moves that item one byte per access. An internal byte offset steps forward on every accepted access. Items sit in two banks, a generic one and an architecture-local one. Each item has a length register, and a length of zero means the item holds no data.

A preload port fills item bytes and lengths before the host runs. Multi-byte integers are laid out least significant byte first, so a 32-bit value comes back low byte first. Host writes land only through keys that carry the write flag. When such a write fills the item, the block gives a one-cycle completion pulse that names the item's index and bank.

Top module: `cfg_select_port`

## Requirements
- R1: After reset the selected key is 0 with offset 0, `sel_found` is 1 and every item length is 0, so a data read gives `rd_valid`=1 with `rd_data`=0.
- R2: A select (`sel_we`) decodes bit 14 as the bank (1 = architecture-local) and bits [IDX_W-1:0] as the item index, ignoring the other bits. An index at or above MAX_ENTRIES makes the key invalid and drives `sel_found` to 0, otherwise 1. Every select sets the offset to 0.
- R3: A data read (`dat_rd` without `dat_we`) gives `rd_valid`=1 one cycle later, with `rd_data` set to the byte at the current offset. The offset then goes up by one.
- R4: A read returns 0 and leaves the offset unchanged when the key is invalid, when the item length is 0, or when the offset is at or past the length.
- R5: A data write (`dat_we`) stores `dat_wdata` at the offset and advances the offset only when key bit 15 (write flag) is set and the offset is below the length. Otherwise it changes nothing.
- R6: The cycle after a write that makes the offset equal to the length, `fill_done` is 1 for exactly that cycle, with `fill_idx` and `fill_local` naming the item.
- R7: A select in the same cycle as a data access is applied after the access: the access uses the old key and offset.
- R8: When `dat_rd` and `dat_we` are both high, the write is performed and the read is dropped (`rd_valid` stays 0).
- R9: A preload length above ITEM_BYTES, or a preload aimed at an invalid index, is ignored. A length equal to ITEM_BYTES is accepted.
- R10: The two banks hold separate data for the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Control-port key write |
| sel_key | input | 16 | Key to select |
| sel_found | output | 1 | Last selected key was valid |
| dat_rd | input | 1 | Data-port byte read |
| dat_we | input | 1 | Data-port byte write |
| dat_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read byte |
| fill_done | output | 1 | Writable item filled (pulse) |
| fill_idx | output | IDX_W | Index of filled item |
| fill_local | output | 1 | Bank of filled item |
| pl_key | input | 16 | Preload target key (bank and index) |
| pl_off | input | OFF_W | Preload byte offset |
| pl_byte_we | input | 1 | Preload byte write |
| pl_byte | input | 8 | Preload byte |
| pl_len_we | input | 1 | Preload length write |
| pl_len | input | 16 | Preload length |

## Verification
The bench builds the block with IDX_W=3, MAX_ENTRIES=6 and ITEM_BYTES=8. Indices 6 and 7 then fit in the index field but count as invalid, which exercises the invalid-key path without stray key bits. An 8-byte item is small enough to read in full to its exhaustion point. A preload length of 9 fits the length field and tests the rejection path.

// File: rtl/cfgsel_pkg.sv
`timescale 1ns/1ps
package cfgsel_pkg;
  localparam int KEY_W     = 16;
  localparam int WR_BIT    = 15;  // write-channel flag
  localparam int LOCAL_BIT = 14;  // architecture-local bank flag
  typedef logic [KEY_W-1:0] key_t;
  typedef logic [7:0]       byte_t;
endpackage

// File: rtl/cfgsel_keydec.sv
`timescale 1ns/1ps
module cfgsel_keydec
  import cfgsel_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int MAX_ENTRIES = 12
) (
  input  key_t             key,
  output logic [IDX_W-1:0] idx,
  output logic             loc,
  output logic             wr,
  output logic             ok
);
  always_comb begin
    idx = key[IDX_W-1:0];
    loc = key[LOCAL_BIT];
    wr  = key[WR_BIT];
    ok  = 32'(idx) < MAX_ENTRIES;
  end
endmodule

// File: rtl/cfgsel_cursor.sv
`timescale 1ns/1ps
module cfgsel_cursor #(
  parameter int IDX_W = 4,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             sel_loc,
  input  logic             sel_wr,
  input  logic             sel_ok,
  input  logic             dat_rd,
  input  logic             dat_we,
  input  logic [LEN_W-1:0] cur_len,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cur_loc,
  output logic [LEN_W-1:0] cur_off,
  output logic             rd_take,
  output logic             rd_zero,
  output logic             wr_take,
  output logic             rd_valid,
  output logic             sel_found,
  output logic             done,
  output logic [IDX_W-1:0] done_idx,
  output logic             done_loc
);
  logic             cur_wr, cur_bad;
  logic [IDX_W-1:0] idx_n;
  logic             loc_n, wr_n, bad_n, found_n;
  logic [LEN_W-1:0] off_n, off_inc;
  logic             avail, rd_req, off_adv, off_en, done_n;

  // access decision uses the key/offset held before any same-cycle select
  always_comb begin
    off_inc = cur_off + LEN_W'(1);
    avail   = !cur_bad && (cur_off < cur_len);
    rd_req  = dat_rd && !dat_we;
    rd_take = rd_req;
    rd_zero = !avail;
    wr_take = dat_we && cur_wr && avail;
    off_adv = (rd_req && avail) || wr_take;
    done_n  = wr_take && (off_inc == cur_len);
  end

  // next state
  always_comb begin
    idx_n   = sel_ok ? sel_idx : '0;
    loc_n   = sel_ok && sel_loc;
    wr_n    = sel_ok && sel_wr;
    bad_n   = !sel_ok;
    found_n = sel_ok;
    off_en  = sel_we || off_adv;
    off_n   = sel_we ? '0 : off_inc;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx   <= '0;
      cur_loc   <= 1'b0;
      cur_wr    <= 1'b0;
      cur_bad   <= 1'b0;
      sel_found <= 1'b1;
      cur_off   <= '0;
      rd_valid  <= 1'b0;
      done      <= 1'b0;
      done_idx  <= '0;
      done_loc  <= 1'b0;
    end else begin
      if (sel_we) begin
        cur_idx   <= idx_n;
        cur_loc   <= loc_n;
        cur_wr    <= wr_n;
        cur_bad   <= bad_n;
        sel_found <= found_n;
      end
      if (off_en) cur_off <= off_n;
      rd_valid <= rd_req;
      done     <= done_n;
      if (wr_take) begin
        done_idx <= cur_idx;
        done_loc <= cur_loc;
      end
    end
  end
endmodule

// File: rtl/cfgsel_store.sv
`timescale 1ns/1ps
module cfgsel_store
  import cfgsel_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int MAX_ENTRIES = 12,
  parameter int LEN_W       = 5,
  parameter int OFF_W       = 4,
  localparam int AW         = 1 + IDX_W + OFF_W,
  localparam int DEPTH      = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_we,
  input  logic             len_loc,
  input  logic [IDX_W-1:0] len_idx,
  input  logic [LEN_W-1:0] len_val,
  input  logic             look_loc,
  input  logic [IDX_W-1:0] look_idx,
  output logic [LEN_W-1:0] look_len,
  input  logic             h_we,
  input  logic [AW-1:0]    h_addr,
  input  byte_t            h_data,
  input  logic             p_we,
  input  logic [AW-1:0]    p_addr,
  input  byte_t            p_data,
  input  logic             r_take,
  input  logic             r_zero,
  input  logic [AW-1:0]    r_addr,
  output byte_t            r_data
);
  logic [LEN_W-1:0] len_q [2][MAX_ENTRIES];
  byte_t            mem   [DEPTH];
  logic             w_en;
  logic [AW-1:0]    w_addr;
  byte_t            w_data;

  // one register per item length
  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar e = 0; e < MAX_ENTRIES; e++) begin : g_ent
      logic hit;
      assign hit = len_we && (len_loc == 1'(b)) && (len_idx == IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   len_q[b][e] <= '0;
        else if (hit) len_q[b][e] <= len_val;
      end
    end
  end

  always_comb begin
    look_len = '0;
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < MAX_ENTRIES; e++)
        if ((look_loc == 1'(b)) && (look_idx == IDX_W'(e))) look_len = len_q[b][e];
  end

  // single write port: host write wins over preload
  always_comb begin
    w_en   = h_we || p_we;
    w_addr = h_we ? h_addr : p_addr;
    w_data = h_we ? h_data : p_data;
  end

  always_ff @(posedge clk) begin
    if (w_en)   mem[w_addr] <= w_data;
    if (r_take) r_data <= r_zero ? 8'h00 : mem[r_addr];
  end
endmodule

// File: rtl/cfg_select_port.sv
`timescale 1ns/1ps
module cfg_select_port
  import cfgsel_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int MAX_ENTRIES = 12,
  parameter int ITEM_BYTES  = 16,
  localparam int LEN_W      = $clog2(ITEM_BYTES + 1),
  localparam int OFF_W      = $clog2(ITEM_BYTES),
  localparam int AW         = 1 + IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [15:0]      sel_key,
  output logic             sel_found,
  input  logic             dat_rd,
  input  logic             dat_we,
  input  logic [7:0]       dat_wdata,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             fill_done,
  output logic [IDX_W-1:0] fill_idx,
  output logic             fill_local,
  input  logic [15:0]      pl_key,
  input  logic [OFF_W-1:0] pl_off,
  input  logic             pl_byte_we,
  input  logic [7:0]       pl_byte,
  input  logic             pl_len_we,
  input  logic [15:0]      pl_len
);
  logic [1:0]       rst_sync;
  logic             rst_q;
  logic [IDX_W-1:0] s_idx, p_idx, cur_idx;
  logic             s_loc, s_wr, s_ok, p_loc, p_wr, p_ok, cur_loc;
  logic [LEN_W-1:0] cur_len, cur_off;
  logic             rd_take, rd_zero, wr_take, len_ok;
  logic [AW-1:0]    cur_addr, pl_addr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  cfgsel_keydec #(.IDX_W(IDX_W), .MAX_ENTRIES(MAX_ENTRIES)) u_sel_dec (
    .key(sel_key), .idx(s_idx), .loc(s_loc), .wr(s_wr), .ok(s_ok));

  cfgsel_keydec #(.IDX_W(IDX_W), .MAX_ENTRIES(MAX_ENTRIES)) u_pl_dec (
    .key(pl_key), .idx(p_idx), .loc(p_loc), .wr(p_wr), .ok(p_ok));

  cfgsel_cursor #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_cursor (
    .clk(clk), .rst_n(rst_q), .sel_we(sel_we), .sel_idx(s_idx), .sel_loc(s_loc),
    .sel_wr(s_wr), .sel_ok(s_ok), .dat_rd(dat_rd), .dat_we(dat_we),
    .cur_len(cur_len), .cur_idx(cur_idx), .cur_loc(cur_loc), .cur_off(cur_off),
    .rd_take(rd_take), .rd_zero(rd_zero), .wr_take(wr_take), .rd_valid(rd_valid),
    .sel_found(sel_found), .done(fill_done), .done_idx(fill_idx), .done_loc(fill_local));

  always_comb begin
    len_ok   = p_ok && (pl_len <= 16'(ITEM_BYTES));
    cur_addr = {cur_loc, cur_idx, cur_off[OFF_W-1:0]};
    pl_addr  = {p_loc, p_idx, pl_off};
  end

  cfgsel_store #(.IDX_W(IDX_W), .MAX_ENTRIES(MAX_ENTRIES), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_store (
    .clk(clk), .rst_n(rst_q),
    .len_we(pl_len_we && len_ok), .len_loc(p_loc), .len_idx(p_idx), .len_val(pl_len[LEN_W-1:0]),
    .look_loc(cur_loc), .look_idx(cur_idx), .look_len(cur_len),
    .h_we(wr_take), .h_addr(cur_addr), .h_data(dat_wdata),
    .p_we(pl_byte_we && p_ok), .p_addr(pl_addr), .p_data(pl_byte),
    .r_take(rd_take), .r_zero(rd_zero), .r_addr(cur_addr), .r_data(rd_data));

  logic unused_ok;
  assign unused_ok = &{1'b0, p_wr};
endmodule

// File: rtl/cfg_select_port_chk.sv
`timescale 1ns/1ps
module cfg_select_port_chk #(
  parameter int IDX_W       = 4,
  parameter int MAX_ENTRIES = 12,
  parameter int LEN_W       = 5
) (
  input logic             clk,
  input logic             rst_q,
  input logic             sel_we,
  input logic [15:0]      sel_key,
  input logic             dat_rd,
  input logic             dat_we,
  input logic             rd_valid,
  input logic             sel_found,
  input logic             fill_done,
  input logic [LEN_W-1:0] cur_off
);
  assert_rd_valid_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (dat_rd && !dat_we) |=> rd_valid);
  assert_no_read_on_write_R8: assert property (@(posedge clk) disable iff (!rst_q)
    dat_we |=> !rd_valid);
  assert_idle_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_q)
    !dat_rd |=> !rd_valid);
  assert_sel_clears_off_R2: assert property (@(posedge clk) disable iff (!rst_q)
    sel_we |=> (cur_off == '0));
  assert_sel_invalid_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (sel_we && (32'(sel_key[IDX_W-1:0]) >= MAX_ENTRIES)) |=> !sel_found);
  assert_sel_valid_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (sel_we && (32'(sel_key[IDX_W-1:0]) < MAX_ENTRIES)) |=> sel_found);
  assert_done_after_write_R6: assert property (@(posedge clk) disable iff (!rst_q)
    fill_done |-> $past(dat_we));
  assert_off_step_R4: assert property (@(posedge clk) disable iff (!rst_q)
    !sel_we |=> ((cur_off == $past(cur_off)) || (cur_off == $past(cur_off) + LEN_W'(1))));
  assert_off_still_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (!sel_we && !dat_rd && !dat_we) |=> $stable(cur_off));
endmodule

bind cfg_select_port cfg_select_port_chk #(.IDX_W(IDX_W), .MAX_ENTRIES(MAX_ENTRIES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .sel_we(sel_we), .sel_key(sel_key), .dat_rd(dat_rd),
  .dat_we(dat_we), .rd_valid(rd_valid), .sel_found(sel_found), .fill_done(fill_done),
  .cur_off(cur_off));

// File: tb/sim_cfg_select_port.sv
`timescale 1ns/1ps
module sim_cfg_select_port;
  localparam int IDX_W = 3, MAXE = 6, ITEM = 8, OFF_W = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sel_we, sel_found, dat_rd, dat_we, rd_valid, fill_done, fill_local;
  logic pl_byte_we, pl_len_we;
  logic [15:0] sel_key, pl_key, pl_len;
  logic [7:0] dat_wdata, rd_data, pl_byte;
  logic [IDX_W-1:0] fill_idx;
  logic [OFF_W-1:0] pl_off;

  int n_chk = 0, n_bad = 0;

  cfg_select_port #(.IDX_W(IDX_W), .MAX_ENTRIES(MAXE), .ITEM_BYTES(ITEM)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_key(sel_key), .sel_found(sel_found),
    .dat_rd(dat_rd), .dat_we(dat_we), .dat_wdata(dat_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .fill_done(fill_done), .fill_idx(fill_idx), .fill_local(fill_local),
    .pl_key(pl_key), .pl_off(pl_off), .pl_byte_we(pl_byte_we), .pl_byte(pl_byte),
    .pl_len_we(pl_len_we), .pl_len(pl_len));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_sel(input logic [15:0] k, output logic found);
    @(negedge clk); sel_we = 1'b1; sel_key = k;
    @(posedge clk); #1; found = sel_found; sel_we = 1'b0;
  endtask

  task automatic do_rd(output logic [7:0] d, output logic v);
    @(negedge clk); dat_rd = 1'b1;
    @(posedge clk); #1; d = rd_data; v = rd_valid; dat_rd = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] b, output logic dn, output logic [IDX_W-1:0] di, output logic dl);
    @(negedge clk); dat_we = 1'b1; dat_wdata = b;
    @(posedge clk); #1; dn = fill_done; di = fill_idx; dl = fill_local; dat_we = 1'b0;
  endtask

  task automatic load_len(input logic [15:0] k, input logic [15:0] n);
    @(negedge clk); pl_len_we = 1'b1; pl_key = k; pl_len = n;
    @(posedge clk); #1; pl_len_we = 1'b0;
  endtask

  task automatic load_byte(input logic [15:0] k, input int off, input logic [7:0] b);
    @(negedge clk); pl_byte_we = 1'b1; pl_key = k; pl_off = OFF_W'(off); pl_byte = b;
    @(posedge clk); #1; pl_byte_we = 1'b0;
  endtask

  // expects a valid read of byte e
  task automatic rd_expect(input string req, input logic [7:0] e);
    logic [7:0] d; logic v;
    do_rd(d, v);
    check(req, "rd_valid", 32'(v), 32'd1);
    check(req, "rd_data", 32'(d), 32'(e));
  endtask

  task automatic t_reset;
    logic f;
    check("R1", "sel_found after reset", 32'(sel_found), 32'd1);
    check("R1", "fill_done after reset", 32'(fill_done), 32'd0);
    check("R1", "rd_valid after reset", 32'(rd_valid), 32'd0);
    rd_expect("R1", 8'h00);
    f = 1'b0;
  endtask

  task automatic t_read_items;
    logic f; logic [31:0] word = 32'h44332211;
    load_len(16'h0002, 16'd4);
    for (int i = 0; i < 4; i++) load_byte(16'h0002, i, word[8*i +: 8]);
    load_len(16'h4002, 16'd3);
    for (int i = 0; i < 3; i++) load_byte(16'h4002, i, 8'hA0 + 8'(i));
    do_sel(16'h0002, f);
    check("R2", "sel_found generic 2", 32'(f), 32'd1);
    for (int i = 0; i < 4; i++) rd_expect("R3", word[8*i +: 8]);
    rd_expect("R4", 8'h00);
    rd_expect("R4", 8'h00);
    do_sel(16'h4002, f);
    for (int i = 0; i < 3; i++) rd_expect("R10", 8'hA0 + 8'(i));
    rd_expect("R4", 8'h00);
    do_sel(16'h0102, f);  // bit 8 is not part of the index
    rd_expect("R2", 8'h11);
  endtask

  task automatic t_invalid_keys;
    logic f;
    do_sel(16'h0006, f);
    check("R2", "sel_found index 6", 32'(f), 32'd0);
    rd_expect("R4", 8'h00);
    do_sel(16'h4007, f);
    check("R2", "sel_found index 7", 32'(f), 32'd0);
    rd_expect("R4", 8'h00);
    do_sel(16'h0002, f);
    check("R2", "sel_found back to valid", 32'(f), 32'd1);
    rd_expect("R2", 8'h11);
  endtask

  task automatic t_reselect;
    logic f;
    do_sel(16'h0002, f);
    rd_expect("R3", 8'h11);
    rd_expect("R3", 8'h22);
    do_sel(16'h0002, f);
    rd_expect("R2", 8'h11);
  endtask

  task automatic t_write_gate;
    logic f, dn, dl; logic [IDX_W-1:0] di;
    load_len(16'h0004, 16'd2);
    load_byte(16'h0004, 0, 8'h00);
    load_byte(16'h0004, 1, 8'h00);
    do_sel(16'h0004, f);
    do_wr(8'h55, dn, di, dl);
    check("R5", "no done without write flag", 32'(dn), 32'd0);
    rd_expect("R5", 8'h00);
    do_sel(16'h8004, f);
    do_wr(8'h5A, dn, di, dl);
    check("R6", "no done before full", 32'(dn), 32'd0);
    do_wr(8'hC3, dn, di, dl);
    check("R6", "done on fill", 32'(dn), 32'd1);
    check("R6", "fill_idx", 32'(di), 32'd4);
    check("R6", "fill_local", 32'(dl), 32'd0);
    do_wr(8'h99, dn, di, dl);
    check("R5", "no done past end", 32'(dn), 32'd0);
    do_sel(16'h0004, f);
    rd_expect("R5", 8'h5A);
    rd_expect("R5", 8'hC3);
    rd_expect("R5", 8'h00);
    do_sel(16'h8005, f);  // length 0 item
    do_wr(8'h12, dn, di, dl);
    check("R5", "no done on empty item", 32'(dn), 32'd0);
    rd_expect("R4", 8'h00);
  endtask

  task automatic t_done_local;
    logic f, dn, dl; logic [IDX_W-1:0] di;
    load_len(16'h4001, 16'd1);
    do_sel(16'hC001, f);
    do_wr(8'h7E, dn, di, dl);
    check("R6", "local done", 32'(dn), 32'd1);
    check("R6", "local fill_idx", 32'(di), 32'd1);
    check("R6", "local fill_local", 32'(dl), 32'd1);
    @(posedge clk); #1;
    check("R6", "done lasts one cycle", 32'(fill_done), 32'd0);
    do_sel(16'h4001, f);
    rd_expect("R10", 8'h7E);
  endtask

  task automatic t_same_cycle_sel;
    logic f;
    do_sel(16'h0002, f);
    rd_expect("R7", 8'h11);
    @(negedge clk); dat_rd = 1'b1; sel_we = 1'b1; sel_key = 16'h4002;
    @(posedge clk); #1;
    check("R7", "valid with select", 32'(rd_valid), 32'd1);
    check("R7", "old key byte", 32'(rd_data), 32'h22);
    dat_rd = 1'b0; sel_we = 1'b0;
    rd_expect("R7", 8'hA0);
  endtask

  task automatic t_collision;
    logic f, dn, dl; logic [IDX_W-1:0] di;
    do_sel(16'h8004, f);
    @(negedge clk); dat_rd = 1'b1; dat_we = 1'b1; dat_wdata = 8'h66;
    @(posedge clk); #1;
    check("R8", "read dropped", 32'(rd_valid), 32'd0);
    check("R8", "no early done", 32'(fill_done), 32'd0);
    dat_rd = 1'b0; dat_we = 1'b0;
    do_wr(8'h77, dn, di, dl);
    check("R8", "write advanced offset", 32'(dn), 32'd1);
    do_sel(16'h0004, f);
    rd_expect("R8", 8'h66);
    rd_expect("R8", 8'h77);
  endtask

  task automatic t_length_limit;
    logic f;
    load_len(16'h0003, 16'd9);
    do_sel(16'h0003, f);
    rd_expect("R9", 8'h00);
    load_len(16'h0003, 16'd8);
    for (int i = 0; i < 8; i++) load_byte(16'h0003, i, 8'h30 + 8'(i));
    load_len(16'h0006, 16'd2);  // invalid index, dropped
    load_byte(16'h0006, 0, 8'hEE);
    do_sel(16'h0003, f);
    for (int i = 0; i < 8; i++) rd_expect("R9", 8'h30 + 8'(i));
    rd_expect("R4", 8'h00);
    do_sel(16'h0002, f);
    rd_expect("R9", 8'h11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_we = 1'b0; sel_key = '0; dat_rd = 1'b0; dat_we = 1'b0; dat_wdata = '0;
    pl_key = '0; pl_off = '0; pl_byte_we = 1'b0; pl_byte = '0; pl_len_we = 1'b0; pl_len = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_read_items();
    t_invalid_keys();
    t_reselect();
    t_write_gate();
    t_done_local();
    t_same_cycle_sel();
    t_collision();
    t_length_limit();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule